// File: doc/BRIEF.md
# Linked DMA Channel Sequencer

This block sequences a small group of logical DMA channels. Each channel is armed through its own control register. A link field in that register names a successor channel, so channels can be chained. A single-cycle hardware start pulse launches the chain head. The chain then runs one channel at a time: each channel raises a transfer request to an external data mover and holds it until the mover returns a completion strobe. Control then passes to the linked channel. When a channel with no valid link completes, the block emits a single-cycle done pulse. The data mover itself is outside the block; only the request/completion handshake is visible here.

Each channel is a small state machine with three states. IDLE is the unarmed state, and configuration is accepted only here. WAITING means armed and waiting for a trigger or a link handoff. ACTIVE means the channel's transfer request is raised. The named transitions are:
- arm: IDLE to WAITING, on a write with enable set and disable clear.
- launch: WAITING to ACTIVE, on a granted hardware start.
- handoff: WAITING to ACTIVE, on a predecessor's link.
- rearm: ACTIVE to WAITING, on completion when not disabled.
- relaunch: ACTIVE to ACTIVE, on completion with a link to itself.
- drop: WAITING to IDLE, on a disable request.
- retire: ACTIVE to IDLE, on completion while a disable is pending.

A disable on an ACTIVE channel is only recorded as pending at first. It takes effect at the next completion.

Software can read any channel's register at any time. The register has these bits:

| Bit(s) | Meaning |
|---|---|
| 0 | enable |
| 1 | disable request (write) / disable pending (read) |
| 2 | hardware start select |
| 4:3 | status, read-only |
| 6:5 | next channel |
| 7 | link valid |

Top module: `dma_chain_seq`

## Requirements
- R1: After reset every channel reads 8'h00 (status IDLE), all transfer requests are low and done is low.
- R2: A write to an IDLE channel stores enable (bit 0), hardware start select (bit 2), next channel (bits 6:5) and link valid (bit 7). If enable is 1 and the disable bit (bit 1) is 0, the channel reads WAITING from the next cycle. The stored enable is the written enable ANDed with the inverse of the disable bit.
- R3: A write to a channel that is not IDLE leaves bits 0, 2, 5, 6 and 7 unchanged. Only its disable bit (bit 1) acts.
- R4: A start pulse moves the lowest-numbered WAITING channel that has hardware start select set to ACTIVE, with its request high from the next cycle. A start pulse that arrives while any channel is ACTIVE is ignored.
- R5: At most one channel is ACTIVE, so at most one transfer request is high, in every cycle.
- R6: A completion strobe on an ACTIVE channel without a disable pending returns it to WAITING. If its link is valid and the named channel is WAITING, that channel is ACTIVE in the next cycle. A link to a channel that is not WAITING is lost. A link to itself keeps the channel ACTIVE.
- R7: Completion of an ACTIVE channel without a valid link and without a disable pending gives exactly one cycle of done, in the cycle after the strobe.
- R8: A disable request (bit 1 written as 1) on a WAITING channel returns it to IDLE in the next cycle, with its stored enable cleared.
- R9: A disable request on an ACTIVE channel keeps it ACTIVE with bit 1 reading 1 until its completion strobe. It then goes to IDLE with enable and the pending flag cleared. It hands off to no successor and raises no done.
- R10: A completion strobe on a channel that is not ACTIVE has no effect on state or done.
- R11: The status field encodes IDLE as 2'b00, WAITING as 2'b01 and ACTIVE as 2'b10; 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 2 | Channel addressed by the write |
| wr_data | input | 8 | Control register write value |
| rd_chan | input | 2 | Channel whose register is shown on rd_data |
| rd_data | output | 8 | Control register view of rd_chan, combinational |
| hw_start | input | 1 | Single-cycle hardware start pulse |
| xfer_req | output | 4 | Per-channel transfer request to the data mover |
| xfer_cmp | input | 4 | Per-channel completion strobe from the data mover |
| done | output | 1 | Single-cycle pulse when the chain tail completes |

## Verification
The assertions take for granted that the mover raises a completion strobe for one cycle at a time. They also assume that hw_start and the write strobe are single-cycle events driven between clock edges. Completion strobes on channels that are not ACTIVE are expected to be ignored, not excluded. The stimulus drives every input on the falling edge and releases each strobe on the following falling edge. It deliberately sends strobes to non-ACTIVE channels, starts while busy, writes to locked channels and disables mid-transfer, so these paths are exercised inside the assumed protocol.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_ACT  = 2'b10
    } ch_state_e;

    localparam int CTL_EN  = 0;
    localparam int CTL_DIS = 1;
    localparam int CTL_HS  = 2;
    localparam int CTL_ST  = 3;
    localparam int CTL_NXT = 5;

endpackage

// File: rtl/seq_chan.sv
module seq_chan #(
    parameter int CW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_sel,
    input  logic                 wr_en_bit,
    input  logic                 wr_dis_bit,
    input  logic                 wr_hs_bit,
    input  logic [CW-1:0]        wr_nxt,
    input  logic                 wr_nv,
    input  logic                 go_hw,
    input  logic                 go_link,
    input  logic                 cmp,
    output seq_pkg::ch_state_e   state_o,
    output logic                 req_o,
    output logic                 fin_ok_o,
    output logic                 en_o,
    output logic                 hs_o,
    output logic                 pend_o,
    output logic [CW-1:0]        nxt_o,
    output logic                 nv_o
);
    import seq_pkg::*;

    ch_state_e     state_q, state_d;
    logic          en_q, hs_q, pend_q, nv_q;
    logic [CW-1:0] nxt_q;
    logic          dis_wr, dis_eff;

    assign dis_wr  = wr_sel && wr_dis_bit;
    assign dis_eff = pend_q || dis_wr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_sel && wr_en_bit && !wr_dis_bit)
                    state_d = ST_WAIT;                  // arm
            end
            ST_WAIT: begin
                if (dis_wr)
                    state_d = ST_IDLE;                  // drop
                else if (go_hw || go_link)
                    state_d = ST_ACT;                   // launch / handoff
            end
            ST_ACT: begin
                if (cmp) begin
                    if (dis_eff)
                        state_d = ST_IDLE;              // retire
                    else if (go_link)
                        state_d = ST_ACT;               // relaunch
                    else
                        state_d = ST_WAIT;              // rearm
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            hs_q   <= 1'b0;
            nxt_q  <= '0;
            nv_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && wr_sel) begin
                en_q  <= wr_en_bit && !wr_dis_bit;
                hs_q  <= wr_hs_bit;
                nxt_q <= wr_nxt;
                nv_q  <= wr_nv;
            end else if (state_d == ST_IDLE && state_q != ST_IDLE) begin
                en_q <= 1'b0;
            end
            if (state_d != ST_ACT)
                pend_q <= 1'b0;
            else if (state_q == ST_ACT && dis_wr)
                pend_q <= 1'b1;
        end
    end

    always_comb begin
        state_o  = state_q;
        req_o    = (state_q == ST_ACT);
        fin_ok_o = (state_q == ST_ACT) && cmp && !dis_eff;
        en_o     = en_q;
        hs_o     = hs_q;
        pend_o   = pend_q;
        nxt_o    = nxt_q;
        nv_o     = nv_q;
    end

    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wr_sel && wr_en_bit && !wr_dis_bit) |=> (state_q == ST_WAIT));

    p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(nxt_q) && $stable(nv_q) && $stable(hs_q)));

    p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && dis_wr) |=> (state_q == ST_IDLE && !en_q));

    p_hold_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACT && !cmp) |=> (state_q == ST_ACT));

    p_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACT && cmp && dis_eff) |=> (state_q == ST_IDLE && !pend_q));

    p_cmp_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACT && !wr_sel && !go_hw && !go_link) |=> $stable(state_q));

    p_state_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != 2'b11));

endmodule

// File: rtl/seq_start_arb.sv
module seq_start_arb #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] cand,
    input  logic [NCH-1:0] busy,
    input  logic           hw_start,
    output logic [NCH-1:0] grant
);
    logic found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        if (hw_start && busy == '0) begin
            for (int i = 0; i < NCH; i++) begin
                if (cand[i] && !found) begin
                    grant[i] = 1'b1;
                    found    = 1'b1;
                end
            end
        end
    end

    always_comb begin
        a_grant_single_r4: assert ($onehot0(grant));
    end

endmodule

// File: rtl/seq_link_xbar.sv
module seq_link_xbar #(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic [NCH-1:0] fin_ok,
    input  logic [NCH-1:0] nv,
    input  logic [CW-1:0]  nxt [NCH],
    output logic [NCH-1:0] go_link,
    output logic           tail_fin
);
    always_comb begin
        go_link  = '0;
        tail_fin = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (fin_ok[i]) begin
                if (nv[i])
                    go_link[nxt[i]] = 1'b1;
                else
                    tail_fin = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
    parameter int NCH = 4,
    parameter int CW  = $clog2(NCH),
    parameter int RW  = seq_pkg::CTL_NXT + CW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CW-1:0]  wr_chan,
    input  logic [RW-1:0]  wr_data,
    input  logic [CW-1:0]  rd_chan,
    output logic [RW-1:0]  rd_data,
    input  logic           hw_start,
    output logic [NCH-1:0] xfer_req,
    input  logic [NCH-1:0] xfer_cmp,
    output logic           done
);
    import seq_pkg::*;

    localparam int NV_BIT = CTL_NXT + CW;

    ch_state_e      st   [NCH];
    logic [CW-1:0]  nxt  [NCH];
    logic [RW-1:0]  view [NCH];
    logic [NCH-1:0] req, fin_ok, en, hs, pend, nv, cand, grant, go_link;
    logic           tail_fin, done_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        seq_chan #(.CW(CW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (wr_en && wr_chan == CW'(g)),
            .wr_en_bit  (wr_data[CTL_EN]),
            .wr_dis_bit (wr_data[CTL_DIS]),
            .wr_hs_bit  (wr_data[CTL_HS]),
            .wr_nxt     (wr_data[CTL_NXT +: CW]),
            .wr_nv      (wr_data[NV_BIT]),
            .go_hw      (grant[g]),
            .go_link    (go_link[g]),
            .cmp        (xfer_cmp[g]),
            .state_o    (st[g]),
            .req_o      (req[g]),
            .fin_ok_o   (fin_ok[g]),
            .en_o       (en[g]),
            .hs_o       (hs[g]),
            .pend_o     (pend[g]),
            .nxt_o      (nxt[g]),
            .nv_o       (nv[g])
        );
        assign cand[g] = (st[g] == ST_WAIT) && hs[g];
        assign view[g] = {nv[g], nxt[g], st[g], hs[g], pend[g], en[g]};
    end

    seq_start_arb #(.NCH(NCH)) u_arb (
        .cand     (cand),
        .busy     (req),
        .hw_start (hw_start),
        .grant    (grant)
    );

    seq_link_xbar #(.NCH(NCH), .CW(CW)) u_xbar (
        .fin_ok   (fin_ok),
        .nv       (nv),
        .nxt      (nxt),
        .go_link  (go_link),
        .tail_fin (tail_fin)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= tail_fin;
    end

    assign done     = done_q;
    assign xfer_req = req;
    assign rd_data  = view[rd_chan];

    p_one_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xfer_req));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_start && xfer_req != '0 && xfer_cmp == '0) |=> $stable(xfer_req));

endmodule

// File: tb/tb_dma_chain_seq.sv
module tb_dma_chain_seq;
    localparam int NCH = 4;

    logic       clk = 0, rst_n = 0;
    logic       wr_en = 0, hw_start = 0;
    logic [1:0] wr_chan = 0, rd_chan = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic [3:0] xfer_req, xfer_cmp = 0;
    logic       done;

    int checks = 0, errors = 0, cycles = 0;

    dma_chain_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
        .rd_chan(rd_chan), .rd_data(rd_data), .hw_start(hw_start),
        .xfer_req(xfer_req), .xfer_cmp(xfer_cmp), .done(done)
    );

    always #10 clk = ~clk;

    // behavioural reference: 0 idle, 1 waiting, 2 active
    int m_st [NCH], m_en [NCH], m_hs [NCH], m_pd [NCH], m_nx [NCH], m_nv [NCH];
    int m_done;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_st[i] = 0; m_en[i] = 0; m_hs[i] = 0; m_pd[i] = 0; m_nx[i] = 0; m_nv[i] = 0;
            end
            m_done = 0;
        end else begin
            int n_st [NCH], n_en [NCH], n_hs [NCH], n_pd [NCH], n_nx [NCH], n_nv [NCH];
            int fok [NCH], lk [NCH];
            int busy, g, dn;
            busy = 0; g = -1; dn = 0;
            for (int i = 0; i < NCH; i++) if (m_st[i] == 2) busy = 1;
            if (hw_start && !busy)
                for (int i = NCH - 1; i >= 0; i--) if (m_st[i] == 1 && m_hs[i] != 0) g = i;
            for (int i = 0; i < NCH; i++) begin
                int dw;
                dw = (wr_en && wr_chan == i && wr_data[1]) ? 1 : 0;
                fok[i] = (m_st[i] == 2 && xfer_cmp[i] && !(m_pd[i] != 0 || dw != 0)) ? 1 : 0;
                lk[i] = 0;
            end
            for (int i = 0; i < NCH; i++)
                if (fok[i] != 0) begin
                    if (m_nv[i] != 0) lk[m_nx[i]] = 1; else dn = 1;
                end
            for (int i = 0; i < NCH; i++) begin
                int w, dw;
                w  = (wr_en && wr_chan == i) ? 1 : 0;
                dw = (w != 0 && wr_data[1]) ? 1 : 0;
                n_st[i] = m_st[i]; n_en[i] = m_en[i]; n_hs[i] = m_hs[i];
                n_pd[i] = m_pd[i]; n_nx[i] = m_nx[i]; n_nv[i] = m_nv[i];
                case (m_st[i])
                    0: if (w != 0) begin
                        n_en[i] = (wr_data[0] && !wr_data[1]) ? 1 : 0;
                        n_hs[i] = wr_data[2];
                        n_nx[i] = wr_data[6:5];
                        n_nv[i] = wr_data[7];
                        if (n_en[i] != 0) n_st[i] = 1;
                    end
                    1: if (dw != 0) begin n_st[i] = 0; n_en[i] = 0; end
                       else if (g == i || lk[i] != 0) n_st[i] = 2;
                    default: begin
                        if (dw != 0) n_pd[i] = 1;
                        if (xfer_cmp[i]) begin
                            if (m_pd[i] != 0 || dw != 0) begin n_st[i] = 0; n_en[i] = 0; n_pd[i] = 0; end
                            else if (lk[i] != 0) n_st[i] = 2;
                            else begin n_st[i] = 1; n_pd[i] = 0; end
                        end
                    end
                endcase
            end
            for (int i = 0; i < NCH; i++) begin
                m_st[i] = n_st[i]; m_en[i] = n_en[i]; m_hs[i] = n_hs[i];
                m_pd[i] = n_pd[i]; m_nx[i] = n_nx[i]; m_nv[i] = n_nv[i];
            end
            m_done = dn;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int m_view(input int c);
        return (m_nv[c] << 7) | (m_nx[c] << 5) | (m_st[c] << 3) | (m_hs[c] << 2) | (m_pd[c] << 1) | m_en[c];
    endfunction

    // per-cycle comparison against the reference, between edges
    always begin
        @(negedge clk);
        #5;
        if (rst_n) begin
            int mr;
            mr = 0;
            for (int i = 0; i < NCH; i++) if (m_st[i] == 2) mr |= (1 << i);
            check("R5 model xfer_req", xfer_req, mr);
            check("R7 model done", done, m_done);
            check("R2 model rd_data", rd_data, m_view(rd_chan));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int ch, input int d);
        @(negedge clk);
        wr_en = 1; wr_chan = 2'(ch); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int ch, output int v);
        @(negedge clk);
        rd_chan = 2'(ch);
        #5 v = rd_data;
    endtask

    task automatic start_pulse();
        @(negedge clk); hw_start = 1;
        @(negedge clk); hw_start = 0;
    endtask

    task automatic cmp_pulse(input int ch);
        @(negedge clk); xfer_cmp[ch] = 1'b1;
        @(negedge clk); xfer_cmp = '0;
    endtask

    initial begin
        int v;
        step(3);
        rst_n = 1;
        for (int c = 0; c < NCH; c++) begin
            rd(c, v);
            check("R1 reset register", v, 0);
        end
        check("R1 reset req", xfer_req, 0);
        check("R1 reset done", done, 0);

        // chain 0->1->2->3, ch0 and ch2 hardware-start capable
        wr(0, 8'hA5); rd(0, v); check("R2 ch0 readback", v, 8'hAD);
        wr(1, 8'hC1); rd(1, v); check("R2 ch1 readback", v, 8'hC9);
        wr(2, 8'hE5); rd(2, v); check("R2 ch2 readback", v, 8'hED);
        wr(3, 8'h01); rd(3, v); check("R2 ch3 readback", v, 8'h09);

        start_pulse();
        #5 check("R4 start launches ch0", xfer_req, 4'b0001);
        rd(0, v); check("R11 active code", (v >> 3) & 3, 2);
        start_pulse();
        rd(2, v); check("R4 start ignored while busy", (v >> 3) & 3, 1);
        check("R4 req unchanged", xfer_req, 4'b0001);
        wr(0, 8'h00); rd(0, v); check("R3 locked config", v, 8'hB5);

        cmp_pulse(0);
        #5 check("R6 handoff to ch1", xfer_req, 4'b0010);
        rd(0, v); check("R6 ch0 rearmed", (v >> 3) & 3, 1);
        cmp_pulse(1);
        #5 check("R6 handoff to ch2", xfer_req, 4'b0100);
        cmp_pulse(2);
        #5 check("R6 handoff to ch3", xfer_req, 4'b1000);
        cmp_pulse(3);
        #5 check("R7 done pulse", done, 1);
        check("R7 chain finished", xfer_req, 0);
        step(1);
        #5 check("R7 done single cycle", done, 0);

        cmp_pulse(3);
        #5 check("R10 stray strobe no done", done, 0);
        rd(3, v); check("R10 ch3 still waiting", v, 8'h09);

        wr(3, 8'h02); rd(3, v); check("R8 disable waiting", v, 8'h00);

        start_pulse();
        cmp_pulse(0); cmp_pulse(1); cmp_pulse(2);
        #5 check("R6 lost link no req", xfer_req, 0);
        check("R6 lost link no done", done, 0);
        step(1);
        #5 check("R6 lost link done stays low", done, 0);

        wr(3, 8'h01);
        start_pulse();
        cmp_pulse(0);
        wr(1, 8'h02);
        rd(1, v); check("R9 pending on active", v, 8'hD3);
        check("R9 still requesting", xfer_req, 4'b0010);
        cmp_pulse(1);
        #5 check("R9 no successor", xfer_req, 0);
        check("R9 no done", done, 0);
        rd(1, v); check("R9 retired to idle", v, 8'hC0);
        rd(2, v); check("R9 ch2 not started", (v >> 3) & 3, 1);

        step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule